// File: doc/BRIEF.md
# Programmable Memory Strobe Timing Sequencer

This block produces the control waveforms for a single bus cycle to an external static memory: an address-valid window, an active-high chip select, a direction line, and a read or write strobe. When the cycle ends it raises a one-tick completion pulse. The sequencer runs on a clock at twice the system rate, so each counted step ("tick") lasts half a system clock. This lets write setup and hold take exact half-clock values.

One chip-select area out of four can be picked for adjusted timing. For that area only, two extra settings apply: a programmable delay from address valid to chip select, and a write setup/hold that is symmetric around the write strobe. Read hold time (strobe release to chip-select release) has its own field for each area, and applies to every area. Writes to the other areas use base timing: chip select rises with the address, the strobe follows one tick later, and chip select drops one tick after the strobe. The configuration is captured when a cycle is accepted and stays fixed until the cycle ends.

Top module: `mst_seq`

## Requirements
- R1: During and after reset with no request, addr_vld_o, cs_o, rd_o, wr_o and done_o are 0 and rw_o is 1.
- R2: Each cycle follows one fixed order. addr_vld_o rises first. cs_o is high only while addr_vld_o is high. cs_o and addr_vld_o both fall in the tick where done_o rises.
- R3: When area_i equals adj_area_i, cs_o rises 2*cs_dly_i ticks after addr_vld_o for codes 0, 1 and 2, and 4 ticks after it for code 3. For other areas the two rise in the same tick.
- R4: For a write to the selected area, wr_o rises 2*wr_dly_i+1 ticks after cs_o (0.5, 1.5, 2.5 or 3.5 system clocks).
- R5: For a write to the selected area, cs_o falls 2*wr_dly_i+1 ticks after wr_o falls.
- R6: A write to an unselected area has wr_o rising 1 tick after cs_o and cs_o falling 1 tick after wr_o.
- R7: In every read, rd_o rises 1 tick after cs_o. cs_o then falls 2*k ticks after rd_o falls, where k is the field rd_hold_i[2a+1:2a] for the target area a. With k=0, cs_o falls in the same tick as rd_o.
- R8: wr_i=1 selects a write and wr_i=0 a read. Each cycle drives exactly one strobe of the selected kind, high for exactly 2 ticks, and never both strobes at once.
- R9: After a cycle is accepted, changes on area_i, wr_i, adj_area_i, cs_dly_i, wr_dly_i and rd_hold_i do not affect that cycle's waveform.
- R10: req_i is accepted only while the sequencer is idle. A request held during a cycle, including its done tick, does not start or alter a cycle.
- R11: rw_o is 0 from the tick cs_o rises to the tick cs_o falls in a write cycle, and 1 at all other times.
- R12: done_o is high for exactly one tick per cycle, the tick right after cs_o was last high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock at twice the system rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Cycle request, taken when idle |
| area_i | input | 2 | Target chip-select area of the request |
| wr_i | input | 1 | 1 = write cycle, 0 = read cycle |
| adj_area_i | input | 2 | Area that gets adjusted setup and write timing |
| cs_dly_i | input | 2 | Address-to-chip-select delay code |
| wr_dly_i | input | 2 | Write setup/hold code |
| rd_hold_i | input | 8 | Per-area read hold codes, area a at bits [2a+1:2a] |
| addr_vld_o | output | 1 | Address valid window |
| cs_o | output | 1 | Chip select, active high |
| rw_o | output | 1 | Direction, 0 during a write's chip-select window |
| rd_o | output | 1 | Read strobe, active high |
| wr_o | output | 1 | Write strobe, active high |
| done_o | output | 1 | One-tick cycle completion pulse |

## Verification
A wrong phase register or counter value shows at the ports within one tick. It moves a cs_o, rd_o or wr_o edge relative to the tick-by-tick expected waveform, or leaves a strobe high for other than two ticks. A wrong captured duration or direction flag can stay hidden until the affected phase is reached, up to about fifteen ticks into the cycle. It then shows as a misplaced edge or a rw_o level that disagrees with the request. The per-tick comparison catches any such deviation in the tick where it occurs.

// File: rtl/mst_pkg.sv
`timescale 1ns/1ps
package mst_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_DONE
  } phase_t;
endpackage

// File: rtl/mst_delay_calc.sv
`timescale 1ns/1ps
// Converts configuration codes into tick counts for the current request.
module mst_delay_calc #(
  parameter int AREAS  = 4,
  parameter int CODE_W = 2,
  parameter int CNT_W  = 4,
  localparam int AW    = $clog2(AREAS)
) (
  input  logic [AW-1:0]           area_i,
  input  logic                    wr_i,
  input  logic [AW-1:0]           adj_area_i,
  input  logic [CODE_W-1:0]       cs_dly_i,
  input  logic [CODE_W-1:0]       wr_dly_i,
  input  logic [AREAS*CODE_W-1:0] rd_hold_i,
  output logic [CNT_W-1:0]        addr_ticks_o,
  output logic [CNT_W-1:0]        setup_ticks_o,
  output logic [CNT_W-1:0]        hold_ticks_o
);
  localparam logic [CNT_W-1:0] BASE_GAP   = CNT_W'(1);
  localparam logic [CODE_W-1:0] CS_RSVD   = {CODE_W{1'b1}};
  localparam logic [CNT_W-1:0] CS_RSVD_TK = CNT_W'(4);

  logic [CODE_W-1:0] hold_code [AREAS];
  logic              sel_hit;
  logic [CNT_W-1:0]  cs_ticks;
  logic [CNT_W-1:0]  wr_ticks;
  logic [CNT_W-1:0]  rd_ticks;

  for (genvar g = 0; g < AREAS; g++) begin : g_hold
    assign hold_code[g] = rd_hold_i[g*CODE_W +: CODE_W];
  end

  always_comb begin
    sel_hit  = (area_i == adj_area_i);
    cs_ticks = (cs_dly_i == CS_RSVD) ? CS_RSVD_TK : CNT_W'({cs_dly_i, 1'b0});
    wr_ticks = CNT_W'({wr_dly_i, 1'b1});
    rd_ticks = CNT_W'({hold_code[area_i], 1'b0});

    addr_ticks_o  = sel_hit ? cs_ticks : '0;
    setup_ticks_o = (sel_hit && wr_i) ? wr_ticks : BASE_GAP;
    if (wr_i) begin
      hold_ticks_o = sel_hit ? wr_ticks : BASE_GAP;
    end else begin
      hold_ticks_o = rd_ticks;
    end
  end
endmodule

// File: rtl/mst_phase_fsm.sv
`timescale 1ns/1ps
// Phase sequencer with one down-counter and durations captured at accept.
module mst_phase_fsm #(
  parameter int CNT_W        = 4,
  parameter int STROBE_TICKS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_i,
  input  logic                wr_i,
  input  logic [CNT_W-1:0]    addr_ticks_i,
  input  logic [CNT_W-1:0]    setup_ticks_i,
  input  logic [CNT_W-1:0]    hold_ticks_i,
  output mst_pkg::phase_t     phase_o,
  output logic                cyc_wr_o
);
  import mst_pkg::*;

  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0] STB_LAST = CNT_W'(STROBE_TICKS - 1);

  phase_t           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] setup_q, hold_q;
  logic             wr_q;
  logic             load_en;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    load_en = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_i) begin
          load_en = 1'b1;
          if (addr_ticks_i != '0) begin
            phase_d = PH_ADDR;
            cnt_d   = addr_ticks_i - ONE;
          end else begin
            phase_d = PH_SETUP;
            cnt_d   = setup_ticks_i - ONE;
          end
        end
      end
      PH_ADDR: begin
        if (cnt_zero) begin
          phase_d = PH_SETUP;
          cnt_d   = setup_q - ONE;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      PH_SETUP: begin
        if (cnt_zero) begin
          phase_d = PH_STROBE;
          cnt_d   = STB_LAST;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      PH_STROBE: begin
        if (cnt_zero) begin
          if (hold_q != '0) begin
            phase_d = PH_HOLD;
            cnt_d   = hold_q - ONE;
          end else begin
            phase_d = PH_DONE;
          end
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      PH_HOLD: begin
        if (cnt_zero) begin
          phase_d = PH_DONE;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      PH_DONE: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= '0;
      hold_q  <= '0;
      wr_q    <= 1'b0;
    end else if (load_en) begin
      setup_q <= setup_ticks_i;
      hold_q  <= hold_ticks_i;
      wr_q    <= wr_i;
    end
  end

  assign phase_o  = phase_q;
  assign cyc_wr_o = wr_q;
endmodule

// File: rtl/mst_pin_decode.sv
`timescale 1ns/1ps
// Maps the registered phase to the bus control levels.
module mst_pin_decode (
  input  mst_pkg::phase_t phase_i,
  input  logic            cyc_wr_i,
  output logic            addr_vld_o,
  output logic            cs_o,
  output logic            rw_o,
  output logic            rd_o,
  output logic            wr_o,
  output logic            done_o
);
  import mst_pkg::*;

  logic cs_win;

  always_comb begin
    cs_win     = (phase_i == PH_SETUP) || (phase_i == PH_STROBE) || (phase_i == PH_HOLD);
    addr_vld_o = cs_win || (phase_i == PH_ADDR);
    cs_o       = cs_win;
    rw_o       = !(cs_win && cyc_wr_i);
    rd_o       = (phase_i == PH_STROBE) && !cyc_wr_i;
    wr_o       = (phase_i == PH_STROBE) && cyc_wr_i;
    done_o     = (phase_i == PH_DONE);
  end
endmodule

// File: rtl/mst_seq.sv
`timescale 1ns/1ps
module mst_seq #(
  parameter int AREAS        = 4,
  parameter int CODE_W       = 2,
  parameter int CNT_W        = 4,
  parameter int STROBE_TICKS = 2,
  localparam int AW          = $clog2(AREAS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_i,
  input  logic [AW-1:0]           area_i,
  input  logic                    wr_i,
  input  logic [AW-1:0]           adj_area_i,
  input  logic [CODE_W-1:0]       cs_dly_i,
  input  logic [CODE_W-1:0]       wr_dly_i,
  input  logic [AREAS*CODE_W-1:0] rd_hold_i,
  output logic                    addr_vld_o,
  output logic                    cs_o,
  output logic                    rw_o,
  output logic                    rd_o,
  output logic                    wr_o,
  output logic                    done_o
);
  logic [CNT_W-1:0] addr_ticks, setup_ticks, hold_ticks;
  mst_pkg::phase_t  phase;
  logic             cyc_wr;

  mst_delay_calc #(
    .AREAS (AREAS),
    .CODE_W(CODE_W),
    .CNT_W (CNT_W)
  ) u_calc (
    .area_i       (area_i),
    .wr_i         (wr_i),
    .adj_area_i   (adj_area_i),
    .cs_dly_i     (cs_dly_i),
    .wr_dly_i     (wr_dly_i),
    .rd_hold_i    (rd_hold_i),
    .addr_ticks_o (addr_ticks),
    .setup_ticks_o(setup_ticks),
    .hold_ticks_o (hold_ticks)
  );

  mst_phase_fsm #(
    .CNT_W       (CNT_W),
    .STROBE_TICKS(STROBE_TICKS)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .wr_i         (wr_i),
    .addr_ticks_i (addr_ticks),
    .setup_ticks_i(setup_ticks),
    .hold_ticks_i (hold_ticks),
    .phase_o      (phase),
    .cyc_wr_o     (cyc_wr)
  );

  mst_pin_decode u_pins (
    .phase_i   (phase),
    .cyc_wr_i  (cyc_wr),
    .addr_vld_o(addr_vld_o),
    .cs_o      (cs_o),
    .rw_o      (rw_o),
    .rd_o      (rd_o),
    .wr_o      (wr_o),
    .done_o    (done_o)
  );
endmodule

// File: rtl/mst_seq_chk.sv
`timescale 1ns/1ps
module mst_seq_chk #(
  parameter int STROBE_TICKS = 2
) (
  input logic clk,
  input logic rst_n,
  input logic addr_vld_o,
  input logic cs_o,
  input logic rw_o,
  input logic rd_o,
  input logic wr_o,
  input logic done_o
);
  logic       stb;
  logic [7:0] stb_run_q;

  assign stb = rd_o || wr_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_run_q <= '0;
    end else if (stb) begin
      stb_run_q <= stb_run_q + 8'd1;
    end else begin
      stb_run_q <= '0;
    end
  end

  // R2
  cs_in_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_o |-> addr_vld_o);
  // R2
  cs_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_o) |-> done_o);
  // R2
  addr_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(addr_vld_o) |-> done_o);
  // R8
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_o && wr_o));
  // R8
  strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> cs_o);
  // R8
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stb) |-> (stb_run_q == 8'(STROBE_TICKS)));
  // R11
  rw_only_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rw_o |-> cs_o);
  // R11
  rw_not_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_o |-> rw_o);
  // R12
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R12
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!cs_o && !addr_vld_o && !stb));
endmodule

bind mst_seq mst_seq_chk #(.STROBE_TICKS(STROBE_TICKS)) u_mst_seq_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr_vld_o(addr_vld_o),
  .cs_o      (cs_o),
  .rw_o      (rw_o),
  .rd_o      (rd_o),
  .wr_o      (wr_o),
  .done_o    (done_o)
);

// File: tb/mst_seq_bench.sv
`timescale 1ns/1ps
module mst_seq_bench;
  logic       clk;
  logic       rst_n;
  logic       req_i;
  logic [1:0] area_i;
  logic       wr_i;
  logic [1:0] adj_area_i;
  logic [1:0] cs_dly_i;
  logic [1:0] wr_dly_i;
  logic [7:0] rd_hold_i;
  logic       addr_vld_o, cs_o, rw_o, rd_o, wr_o, done_o;

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    finished = 0;
  bit    model_idle;
  string scen = "base";

  // expected vector bits: {done, wr, rd, rw_low, cs, addr}
  logic [5:0] q_vec[$];
  string      q_tag[$];

  mst_seq u_mst_seq (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .area_i(area_i), .wr_i(wr_i),
    .adj_area_i(adj_area_i), .cs_dly_i(cs_dly_i), .wr_dly_i(wr_dly_i),
    .rd_hold_i(rd_hold_i), .addr_vld_o(addr_vld_o), .cs_o(cs_o), .rw_o(rw_o),
    .rd_o(rd_o), .wr_o(wr_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      report();
      $finish;
    end
  end

  task automatic push_n(int n, logic [5:0] v, string tag);
    for (int i = 0; i < n; i++) begin
      q_vec.push_back(v);
      q_tag.push_back(tag);
    end
  endtask

  // Behavioural expectation of one cycle accepted at the coming edge.
  task automatic model_accept();
    bit  hit;
    int  a_t, s_t, h_t, k;
    logic [5:0] cyc, stb;
    hit = (area_i == adj_area_i);
    a_t = hit ? ((cs_dly_i == 2'd3) ? 4 : 2 * cs_dly_i) : 0;
    s_t = (hit && wr_i) ? 2 * wr_dly_i + 1 : 1;
    k   = rd_hold_i[area_i*2 +: 2];
    h_t = wr_i ? (hit ? 2 * wr_dly_i + 1 : 1) : 2 * k;
    cyc = wr_i ? 6'b000111 : 6'b000011;
    stb = wr_i ? 6'b010111 : 6'b001011;
    push_n(a_t, 6'b000001, "R3 addr-to-cs");
    push_n(s_t, cyc, wr_i ? (hit ? "R4/R11 write setup" : "R6/R11 base setup") : "R7 read setup");
    push_n(2, stb, "R8 strobe");
    push_n(h_t, cyc, wr_i ? (hit ? "R5/R11 write hold" : "R6/R11 base hold") : "R7 read hold");
    push_n(1, 6'b100000, "R12/R2 done");
  endtask

  task automatic step();
    logic [5:0] exp_v, act_v;
    string tag;
    @(negedge clk);
    #1;
    model_idle = (q_vec.size() == 0);
    if (model_idle) begin
      exp_v = 6'b000000;
      tag   = "R1/R10 idle";
    end else begin
      exp_v = q_vec.pop_front();
      tag   = q_tag.pop_front();
    end
    act_v = {done_o, wr_o, rd_o, !rw_o, cs_o, addr_vld_o};
    n_checks++;
    if (act_v !== exp_v) begin
      n_fails++;
      $display("FAIL %s [%s] at %0t: actual=%b expected=%b", tag, scen, $time, act_v, exp_v);
    end
  endtask

  task automatic scramble();
    area_i     = 2'($urandom);
    wr_i       = 1'($urandom);
    adj_area_i = 2'($urandom);
    cs_dly_i   = 2'($urandom);
    wr_dly_i   = 2'($urandom);
    rd_hold_i  = 8'($urandom);
  endtask

  // Called right after a step with model_idle set.
  task automatic do_cycle(logic [1:0] ar, logic w, logic [1:0] sel,
                          logic [1:0] csd, logic [1:0] wrd, logic [7:0] rdh, bit noisy);
    area_i = ar; wr_i = w; adj_area_i = sel;
    cs_dly_i = csd; wr_dly_i = wrd; rd_hold_i = rdh;
    req_i = 1'b1;
    model_accept();
    forever begin
      step();
      if (model_idle) break;
      if (noisy) begin
        // R9 config churn and R10 held request during the cycle
        scramble();
        req_i = 1'b1;
      end else begin
        req_i = 1'b0;
      end
    end
    req_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; req_i = 1'b0; area_i = '0; wr_i = 1'b0;
    adj_area_i = '0; cs_dly_i = '0; wr_dly_i = '0; rd_hold_i = '0;
    scen = "R1 reset";
    step();
    req_i = 1'b1;          // R1: ignored while in reset
    step();
    req_i = 1'b0;
    rst_n = 1'b1;
    step();
    step();

    // Default configuration: selected area 0, all codes zero.
    scen = "R6 defaults";
    do_cycle(2'd1, 1'b1, 2'd0, 2'd0, 2'd0, 8'h00, 1'b0);
    scen = "R4 default 0.5";
    do_cycle(2'd0, 1'b1, 2'd0, 2'd0, 2'd0, 8'h00, 1'b0);
    scen = "R7 default hold";
    do_cycle(2'd2, 1'b0, 2'd0, 2'd0, 2'd0, 8'h00, 1'b0);

    // Every area, every selected area, both directions, every code.
    for (int sel = 0; sel < 4; sel++) begin
      for (int ar = 0; ar < 4; ar++) begin
        for (int w = 0; w < 2; w++) begin
          for (int c = 0; c < 4; c++) begin
            logic [7:0] rdh;
            for (int k = 0; k < 4; k++) rdh[k*2 +: 2] = 2'((c + k) % 4);
            scen = (c % 2 == 1) ? "R9/R10 noisy" : "R3/R5/R7 sweep";
            do_cycle(2'(ar), 1'(w), 2'(sel), 2'(c), 2'(3 - c), rdh, (c % 2 == 1));
          end
        end
      end
    end

    // R10: request held across the done tick then dropped.
    scen = "R10 held";
    do_cycle(2'd3, 1'b1, 2'd3, 2'd3, 2'd3, 8'hFF, 1'b1);
    scen = "R1 tail";
    step();
    step();

    finished = 1;
    report();
    $finish;
  end
endmodule